// File: doc/BRIEF.md
# Pipelined Byte-Lane Synchronous SRAM

This block is a small synchronous memory with a pipelined read path. The default size is 256 words of 18 bits. Each word is split into two 9-bit lanes, and each lane holds 8 data bits plus one parity bit. Every control, address and write-data input is captured on the rising clock edge. Read data then moves through an internal array stage and a final output register before it reaches the pins.

Writes can be narrowed to single lanes with a lane-select field, which is qualified by a lane-write enable. A global write input overrides both of those and writes every lane. Three chip-select inputs of mixed polarity must all be active before any access takes place. An asynchronous, active-low output enable gates a drive flag, and that flag is the tri-state control for the shared data bus. The drive flag is held off for any pipeline slot that does not carry read data. As a result, the first clock of a read that follows a deselected cycle never drives the bus.

Top module: `sram_pipe_byte`

## Requirements
- R1: Inputs are sampled on the rising edge. The word read from the address sampled at edge N appears on `rdata_o` after edge N+2.
- R2: An access takes place only when `sel_a_n_i`=0, `sel_b_i`=1 and `sel_c_n_i`=0. Any other combination performs no write and no read.
- R3: When `all_wr_i`=1 on a selected cycle, both lanes are written. This holds whatever `lane_wr_en_i` and `lane_pick_i` are.
- R4: When `all_wr_i`=0 and `lane_wr_en_i`=1, only the lanes set in `lane_pick_i` are written. Bit 0 selects `wdata_i[8:0]` and bit 1 selects `wdata_i[17:9]`. Lanes that are not selected keep their contents.
- R5: A selected cycle is a read when `all_wr_i`=0 and either `lane_wr_en_i`=0 or `lane_pick_i`=00. In that case `lane_pick_i` has no effect.
- R6: While the output slot holds read data, `rdata_drive_o` equals the inverse of `oe_n_i`. It follows `oe_n_i` with no clock edge in between.
- R7: For an output slot that came from a deselected or write cycle, `rdata_drive_o` is 0 whatever `oe_n_i` is. This includes the slot just before the first read after a deselect.
- R8: `rdata_o` keeps the last read word until the next read result reaches the output.
- R9: A write followed on the next cycle by a read of the same address returns the newly written word.
- R10: During and after reset, `rdata_o` is 0 and `rdata_drive_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of the pipeline |
| addr_i | input | 8 | Word address |
| wdata_i | input | 18 | Write word, two 9-bit lanes |
| sel_a_n_i | input | 1 | Chip select, active low |
| sel_b_i | input | 1 | Chip select, active high |
| sel_c_n_i | input | 1 | Chip select, active low |
| all_wr_i | input | 1 | Global write, writes all lanes |
| lane_wr_en_i | input | 1 | Qualifier for lane writes |
| lane_pick_i | input | 2 | Per-lane write select |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| rdata_o | output | 18 | Registered read word |
| rdata_drive_o | output | 1 | Bus drive flag for `rdata_o` |

## Verification
A lost or shifted read-valid bit in the pipeline shows up at the ports exactly three edges after the affected input cycle. It appears either as the drive flag rising for a write or deselect slot, or as the flag staying low under a read. A wrong captured lane mask or a missed chip-select decode stays hidden in the array until that address is read back. The vector walk therefore reads every written location within one or two cycles of the write. A stale or corrupted output register is caught by comparing `rdata_o` in every slot, including the slots where no read has arrived.

// File: rtl/sram_pkg.sv
package sram_pkg;

    // Operation decoded from one sampled input cycle
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

endpackage

// File: rtl/sram_op_decode.sv
module sram_op_decode
    import sram_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             sel_a_n,
    input  logic             sel_b,
    input  logic             sel_c_n,
    input  logic             all_wr,
    input  logic             lane_wr_en,
    input  logic [LANES-1:0] lane_pick,
    output op_e              op,
    output logic [LANES-1:0] lane_mask
);

    logic chip_on;
    logic wr_req;

    always_comb begin
        chip_on = !sel_a_n && sel_b && !sel_c_n;
        wr_req  = all_wr || (lane_wr_en && (|lane_pick));
        op        = OP_IDLE;
        lane_mask = '0;
        if (chip_on) begin
            if (wr_req) begin
                op        = OP_WRITE;
                lane_mask = all_wr ? {LANES{1'b1}} : lane_pick;
            end else begin
                op = OP_READ;
            end
        end
    end

endmodule

// File: rtl/sram_lane_bank.sv
module sram_lane_bank #(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 9,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANE_W-1:0] wr_data,
    output logic [LANE_W-1:0] rd_data
);

    logic [LANE_W-1:0] mem_q [DEPTH];
    logic [LANE_W-1:0] rd_q;

    // Single-port lane: the registered read is always taken, the write only on demand
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[addr] <= wr_data;
        end
        rd_q <= mem_q[addr];
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/sram_pipe_byte.sv
module sram_pipe_byte
    import sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    localparam int WORD_W = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              sel_a_n_i,
    input  logic              sel_b_i,
    input  logic              sel_c_n_i,
    input  logic              all_wr_i,
    input  logic              lane_wr_en_i,
    input  logic [LANES-1:0]  lane_pick_i,
    input  logic              oe_n_i,
    output logic [WORD_W-1:0] rdata_o,
    output logic              rdata_drive_o
);

    typedef struct packed {
        op_e               op;        // sampled operation
        logic [ADDR_W-1:0] addr;      // sampled address
        logic [WORD_W-1:0] wdata;     // sampled write word
        logic [LANES-1:0]  mask;      // sampled lane mask
        logic              rd_pend;   // array stage holds a read
        logic              out_rd;    // output stage holds a read
        logic [WORD_W-1:0] out_data;  // output register
    } pipe_t;

    pipe_t             st_d;
    pipe_t             st_q;
    op_e               dec_op;
    logic [LANES-1:0]  dec_mask;
    logic [WORD_W-1:0] bank_word;

    sram_op_decode #(.LANES(LANES)) u_decode (
        .sel_a_n    (sel_a_n_i),
        .sel_b      (sel_b_i),
        .sel_c_n    (sel_c_n_i),
        .all_wr     (all_wr_i),
        .lane_wr_en (lane_wr_en_i),
        .lane_pick  (lane_pick_i),
        .op         (dec_op),
        .lane_mask  (dec_mask)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        sram_lane_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_bank (
            .clk     (clk),
            .wr_en   ((st_q.op == OP_WRITE) && st_q.mask[l]),
            .addr    (st_q.addr),
            .wr_data (st_q.wdata[l*LANE_W +: LANE_W]),
            .rd_data (bank_word[l*LANE_W +: LANE_W])
        );
    end

    always_comb begin
        st_d          = st_q;
        st_d.op       = dec_op;
        st_d.addr     = addr_i;
        st_d.wdata    = wdata_i;
        st_d.mask     = dec_mask;
        st_d.rd_pend  = (st_q.op == OP_READ);
        st_d.out_rd   = st_q.rd_pend;
        if (st_q.rd_pend) begin
            st_d.out_data = bank_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o       = st_q.out_data;
    assign rdata_drive_o = st_q.out_rd && !oe_n_i;

endmodule

// File: rtl/sram_pipe_byte_chk.sv
module sram_pipe_byte_chk #(
    parameter int LANES  = 2,
    parameter int WORD_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_a_n_i,
    input logic              sel_b_i,
    input logic              sel_c_n_i,
    input logic              all_wr_i,
    input logic              lane_wr_en_i,
    input logic [LANES-1:0]  lane_pick_i,
    input logic              oe_n_i,
    input logic [WORD_W-1:0] rdata_o,
    input logic              rdata_drive_o
);

    logic sel_in;
    logic wr_in;

    always_comb begin
        sel_in = !sel_a_n_i && sel_b_i && !sel_c_n_i;
        wr_in  = all_wr_i || (lane_wr_en_i && (|lane_pick_i));
    end

    AST_DESEL_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_in |-> ##3 !rdata_drive_o); // R7

    AST_WRITE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_in && wr_in) |-> ##3 !rdata_drive_o); // R7

    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_in && !wr_in) |-> ##3 (rdata_drive_o == !oe_n_i)); // R6

    AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_in && !wr_in) |-> ##3 $stable(rdata_o)); // R8

endmodule

bind sram_pipe_byte sram_pipe_byte_chk #(.LANES(LANES), .WORD_W(WORD_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sel_a_n_i     (sel_a_n_i),
    .sel_b_i       (sel_b_i),
    .sel_c_n_i     (sel_c_n_i),
    .all_wr_i      (all_wr_i),
    .lane_wr_en_i  (lane_wr_en_i),
    .lane_pick_i   (lane_pick_i),
    .oe_n_i        (oe_n_i),
    .rdata_o       (rdata_o),
    .rdata_drive_o (rdata_drive_o)
);

// File: tb/sram_pipe_byte_bench.sv
module sram_pipe_byte_bench;

    localparam int NV = 16;
    localparam logic [2:0] ON  = 3'b010;  // {sel_a_n, sel_b, sel_c_n} active
    localparam logic [2:0] OFF = 3'b110;  // first select inactive

    // {sel[2:0], all_wr, lane_wr_en, lane_pick[1:0], addr[7:0], wdata[17:0]}
    localparam logic [32:0] VEC [NV] = '{
        {ON,     1'b1, 1'b0, 2'b00, 8'd5,  18'h2A5A5},  // R3 global write
        {ON,     1'b0, 1'b0, 2'b00, 8'd5,  18'h00000},  // R9 read right after write
        {ON,     1'b0, 1'b1, 2'b01, 8'd5,  18'h001FF},  // R4 lane 0 only
        {ON,     1'b0, 1'b0, 2'b00, 8'd5,  18'h00000},  // R4 read back
        {ON,     1'b1, 1'b0, 2'b00, 8'd9,  18'h3FFFF},  // R3
        {ON,     1'b0, 1'b1, 2'b10, 8'd9,  18'h00000},  // R4 lane 1 only
        {ON,     1'b0, 1'b0, 2'b00, 8'd9,  18'h00000},  // R1 read
        {OFF,    1'b1, 1'b0, 2'b00, 8'd9,  18'h00000},  // R2 blocked write
        {ON,     1'b0, 1'b0, 2'b00, 8'd9,  18'h00000},  // R7 read after deselect
        {3'b000, 1'b0, 1'b0, 2'b00, 8'd5,  18'h00000},  // R2 sel_b low
        {3'b011, 1'b1, 1'b0, 2'b00, 8'd5,  18'h00000},  // R2 sel_c_n high
        {ON,     1'b0, 1'b1, 2'b00, 8'd5,  18'h00000},  // R5 empty pick reads
        {ON,     1'b1, 1'b0, 2'b00, 8'd20, 18'h15555},  // R3 pick ignored
        {ON,     1'b0, 1'b0, 2'b11, 8'd20, 18'h00000},  // R5 pick ignored on read
        {ON,     1'b1, 1'b1, 2'b01, 8'd20, 18'h0AAAA},  // R3 overrides lanes
        {ON,     1'b0, 1'b0, 2'b00, 8'd20, 18'h00000}   // R8 read
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr_i = '0;
    logic [17:0] wdata_i = '0;
    logic        sel_a_n_i = 1'b1, sel_b_i = 1'b0, sel_c_n_i = 1'b1;
    logic        all_wr_i = 1'b0, lane_wr_en_i = 1'b0;
    logic [1:0]  lane_pick_i = '0;
    logic        oe_n_i = 1'b0;
    logic [17:0] rdata_o;
    logic        rdata_drive_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    logic [17:0] ref_mem [256];
    logic [17:0] ref_hold = '0;
    logic        hist_drv [NV+3];
    logic [17:0] hist_dat [NV+3];

    always #10 clk = ~clk;

    sram_pipe_byte u_sram_pipe_byte (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wdata_i(wdata_i),
        .sel_a_n_i(sel_a_n_i), .sel_b_i(sel_b_i), .sel_c_n_i(sel_c_n_i),
        .all_wr_i(all_wr_i), .lane_wr_en_i(lane_wr_en_i), .lane_pick_i(lane_pick_i),
        .oe_n_i(oe_n_i), .rdata_o(rdata_o), .rdata_drive_o(rdata_drive_o)
    );

    function automatic string vec_tag(int k);
        case (k)
            0, 12, 14: return "R3";
            1:         return "R9";
            2, 3, 5:   return "R4";
            4:         return "R3";
            6:         return "R1";
            7, 9, 10:  return "R2";
            8:         return "R7";
            11, 13:    return "R5";
            default:   return "R8";
        endcase
    endfunction

    task automatic check_bit(string tag, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s drive: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic check_word(string tag, logic [17:0] act, logic [17:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s data: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Apply one cycle's inputs and advance the reference model
    task automatic apply(logic [32:0] v, int slot);
        logic on, wr;
        logic [1:0] msk;
        {sel_a_n_i, sel_b_i, sel_c_n_i} = v[32:30];
        all_wr_i     = v[29];
        lane_wr_en_i = v[28];
        lane_pick_i  = v[27:26];
        addr_i       = v[25:18];
        wdata_i      = v[17:0];
        on  = (v[32:30] == ON);
        wr  = v[29] || (v[28] && (|v[27:26]));
        msk = v[29] ? 2'b11 : v[27:26];
        if (on && wr) begin
            if (msk[0]) ref_mem[v[25:18]][8:0]  = v[8:0];
            if (msk[1]) ref_mem[v[25:18]][17:9] = v[17:9];
        end
        if (on && !wr) ref_hold = ref_mem[v[25:18]];
        hist_drv[slot] = on && !wr;
        hist_dat[slot] = ref_hold;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) ref_mem[i] = '0;
        repeat (3) @(negedge clk);
        check_bit("R10", rdata_drive_o, 1'b0);
        check_word("R10", rdata_o, 18'h0);
        rst_n = 1'b1;

        // Vector walk: result of slot k is sampled three falling edges after it
        for (int j = 0; j < NV + 3; j++) begin
            if (j >= 3) begin
                check_bit(vec_tag(j-3), rdata_drive_o, hist_drv[j-3]);
                check_word(vec_tag(j-3), rdata_o, hist_dat[j-3]);
            end
            if (j < NV) apply(VEC[j], j);
            else apply({OFF, 1'b0, 1'b0, 2'b00, 8'd0, 18'h0}, j);
            @(negedge clk);
        end

        // R6: output enable acts without a clock edge
        apply({ON, 1'b0, 1'b0, 2'b00, 8'd9, 18'h0}, 0);
        @(negedge clk);
        apply({OFF, 1'b0, 1'b0, 2'b00, 8'd0, 18'h0}, 1);
        repeat (2) @(negedge clk);
        check_bit("R6", rdata_drive_o, 1'b1);
        check_word("R6", rdata_o, 18'h001FF);
        #2 oe_n_i = 1'b1;
        #1 check_bit("R6", rdata_drive_o, 1'b0);
        #2 oe_n_i = 1'b0;
        #1 check_bit("R6", rdata_drive_o, 1'b1);
        @(negedge clk);
        check_bit("R7", rdata_drive_o, 1'b0);
        check_word("R8", rdata_o, 18'h001FF);

        // R10: reset in mid-run clears the output
        apply({ON, 1'b0, 1'b0, 2'b00, 8'd20, 18'h0}, 2);
        repeat (3) @(negedge clk);
        check_bit("R1", rdata_drive_o, 1'b1);
        check_word("R1", rdata_o, 18'h0AAAA);
        rst_n = 1'b0;
        @(negedge clk);
        check_bit("R10", rdata_drive_o, 1'b0);
        check_word("R10", rdata_o, 18'h0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            repeat (100000) @(posedge clk);
        join_any
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule